// File: doc/BRIEF.md
# SIMD Modified-Immediate Logic Unit

This unit decodes one 32-bit vector modified-immediate instruction word and executes it against the current 128-bit value of its destination register. It recognises four operations: move, move-inverted, OR and bit-clear. It builds an 8-bit immediate from two split fields and shifts it inside 32-bit or 16-bit lanes. It then replicates that pattern across a 64-bit or 128-bit data width and returns the new register value, a write enable, the destination index and two exception flags. The flags mark an undefined encoding and a form this unit does not implement. The register file is outside the unit. The caller reads the destination register, presents its value with the word, and writes the result back when the write enable is set.

Words and operands arrive on a valid/ready input. Results leave on a valid/ready output through a single register stage. A word is taken on a clock edge where both `in_valid` and `in_ready` are high. Its result appears on the outputs in the following cycle with `out_valid` high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output fields hold their values and no new word is taken.

Top module: `simd_imm_unit`

## Requirements
- R1: A word is recognised only when all of the following hold: bit 31 = 0, bits 28..19 = 0111100000, bit 11 = 0 and bit 10 = 1. For any other word the result has `out_wr`, `out_undef` and `out_unsup` all low and `out_result` zero.
- R2: The immediate is built from two fields: bits 18..16 form its top three bits and bits 9..5 form its low five bits. `out_rd` always equals bits 4..0 of the accepted word.
- R3: When the selector (bits 15..12) has its top bit 0, the immediate is shifted left by 8 × selector[2:1] inside a 32-bit lane, and that lane is repeated across the data width.
- R4: When selector[3:2] = 10, the immediate is shifted left by 8 × selector[1] inside a 16-bit lane, and that lane is repeated across the data width.
- R5: The operation code is {selector[0], bit 29}. The codes are 00 = move (result is the pattern), 01 = move-inverted (result is NOT pattern), 10 = OR (result is old value OR pattern) and 11 = bit-clear (result is old value AND NOT pattern).
- R6: Bit 30 = 1 gives a 128-bit operation. Bit 30 = 0 gives a 64-bit operation on the low half, and bits 127..64 of the result are zero.
- R7: A recognised word with selector = 1111, bit 29 = 1 and bit 30 = 0 raises `out_undef` only, with `out_wr` low and `out_result` zero.
- R8: Any other recognised word with selector[3:2] = 11 raises `out_unsup` only, with `out_wr` low and `out_result` zero. At most one of `out_wr`, `out_undef` and `out_unsup` is ever high.
- R9: `in_ready` equals NOT `out_valid` OR `out_ready`. The result of an accepted word appears one cycle after it is taken. While `out_valid` is high and `out_ready` is low, all output fields stay unchanged.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word and operand are present |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_instr | input | 32 | Instruction word |
| in_old | input | 128 | Current value of the destination register |
| out_valid | output | 1 | Result fields are valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 128 | New destination register value |
| out_wr | output | 1 | Result must be written back |
| out_rd | output | 5 | Destination register index |
| out_undef | output | 1 | Word is an undefined encoding |
| out_unsup | output | 1 | Word is a form this unit does not implement |

## Verification
The bound checker watches properties on every cycle:
- the output holds steady while the consumer stalls, and the input is refused during a stall;
- the write enable and the two flags are mutually exclusive;
- an unrecognised word never raises anything;
- the undefined encoding always raises its flag;
- the upper half is zero for 64-bit writes;
- the destination index follows the accepted word.

The actual bit patterns can only be shown by the bench's scenarios, which compare every result against a reference model. These cover each lane width and shift amount, each of the four operations against chosen old values, and a stalled word that must not be lost.

// File: rtl/simd_imm_pkg.sv
package simd_imm_pkg;
  localparam int INSTR_W = 32;
  localparam int VEC_W   = 128;
  localparam int CHUNK_W = 64;
  localparam int IMM_W   = 8;
  localparam int RD_W    = 5;
  localparam int SEL_W   = 4;
  localparam int NCHUNK  = VEC_W / CHUNK_W;

  typedef enum logic [1:0] {
    OP_MOVE     = 2'b00,
    OP_MOVE_INV = 2'b01,
    OP_OR       = 2'b10,
    OP_CLEAR    = 2'b11
  } imm_op_e;

  typedef struct packed {
    logic             match;
    logic             wr;
    logic             undef;
    logic             unsup;
    logic             wide;
    imm_op_e          op;
    logic [SEL_W-1:0] sel;
    logic [IMM_W-1:0] imm8;
    logic [RD_W-1:0]  rd;
  } dec_t;
endpackage

// File: rtl/simd_imm_decode.sv
module simd_imm_decode
  import simd_imm_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic reserved;
  logic bad_width;

  always_comb begin
    dec.match = (instr[31] == 1'b0) && (instr[28:19] == 10'b0111100000) &&
                (instr[11:10] == 2'b01);
    dec.sel   = instr[15:12];
    dec.imm8  = {instr[18:16], instr[9:5]};
    dec.rd    = instr[4:0];
    dec.wide  = instr[30];
    dec.op    = imm_op_e'({instr[12], instr[29]});
    reserved  = (instr[15:14] == 2'b11);
    bad_width = reserved && (instr[13:12] == 2'b11) && instr[29] && !instr[30];
    dec.undef = dec.match && bad_width;
    dec.unsup = dec.match && reserved && !bad_width;
    dec.wr    = dec.match && !reserved;
  end
endmodule

// File: rtl/simd_imm_expand.sv
module simd_imm_expand
  import simd_imm_pkg::*;
(
  input  logic [SEL_W-1:0]   sel,
  input  logic [IMM_W-1:0]   imm8,
  output logic [CHUNK_W-1:0] pattern
);
  localparam int N32 = CHUNK_W / 32;
  localparam int N16 = CHUNK_W / 16;

  logic [31:0]        word;
  logic [15:0]        half;
  logic [CHUNK_W-1:0] pat32;
  logic [CHUNK_W-1:0] pat16;

  always_comb begin
    word = 32'(imm8) << {sel[2:1], 3'b000};
    half = 16'(imm8) << {sel[1], 3'b000};
  end

  for (genvar i = 0; i < N32; i++) begin : g_word
    assign pat32[i*32 +: 32] = word;
  end
  for (genvar j = 0; j < N16; j++) begin : g_half
    assign pat16[j*16 +: 16] = half;
  end

  assign pattern = sel[3] ? pat16 : pat32;
endmodule

// File: rtl/simd_imm_alu.sv
module simd_imm_alu
  import simd_imm_pkg::*;
(
  input  imm_op_e            op,
  input  logic               wide,
  input  logic [VEC_W-1:0]   old,
  input  logic [CHUNK_W-1:0] pattern,
  output logic [VEC_W-1:0]   result
);
  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    localparam bit FIRST = (g == 0);
    logic [CHUNK_W-1:0] src;
    logic [CHUNK_W-1:0] val;
    logic               live;

    assign src  = old[g*CHUNK_W +: CHUNK_W];
    assign live = wide || FIRST;

    always_comb begin
      unique case (op)
        OP_MOVE:     val = pattern;
        OP_MOVE_INV: val = ~pattern;
        OP_OR:       val = src | pattern;
        OP_CLEAR:    val = src & ~pattern;
        default:     val = '0;
      endcase
    end

    assign result[g*CHUNK_W +: CHUNK_W] = live ? val : '0;
  end
endmodule

// File: rtl/simd_imm_unit.sv
module simd_imm_unit
  import simd_imm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [INSTR_W-1:0]  in_instr,
  input  logic [VEC_W-1:0]    in_old,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [VEC_W-1:0]    out_result,
  output logic                out_wr,
  output logic [RD_W-1:0]     out_rd,
  output logic                out_undef,
  output logic                out_unsup
);
  dec_t               dec;
  logic [CHUNK_W-1:0] pattern;
  logic [VEC_W-1:0]   result_next;
  logic               accept;

  simd_imm_decode u_dec (.instr(in_instr), .dec(dec));

  simd_imm_expand u_exp (.sel(dec.sel), .imm8(dec.imm8), .pattern(pattern));

  simd_imm_alu u_alu (
    .op(dec.op), .wide(dec.wide), .old(in_old),
    .pattern(pattern), .result(result_next)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr     <= 1'b0;
      out_rd     <= '0;
      out_undef  <= 1'b0;
      out_unsup  <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= dec.wr ? result_next : '0;
      out_wr     <= dec.wr;
      out_rd     <= dec.rd;
      out_undef  <= dec.undef;
      out_unsup  <= dec.unsup;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_imm_unit_chk.sv
module simd_imm_unit_chk
  import simd_imm_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [INSTR_W-1:0] in_instr,
  input logic               out_valid,
  input logic               out_ready,
  input logic [VEC_W-1:0]   out_result,
  input logic               out_wr,
  input logic [RD_W-1:0]    out_rd,
  input logic               out_undef,
  input logic               out_unsup
);
  logic [INSTR_W-1:0] seen;
  logic               seen_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && in_ready) seen <= in_instr;
  end

  assign seen_match = !seen[31] && (seen[28:19] == 10'b0111100000) &&
                      !seen[11] && seen[10];

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
      $stable(out_wr) && $stable(out_rd) && $stable(out_undef) && $stable(out_unsup));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_wr, out_undef, out_unsup}));

  assert_nomatch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !seen_match |-> !out_wr && !out_undef && !out_unsup);

  assert_undef_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && seen_match && seen[15:12] == 4'hF && seen[29] && !seen[30]
      |-> out_undef && !out_wr);

  assert_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wr && !seen[30] |-> out_result[VEC_W-1:CHUNK_W] == '0);

  assert_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_rd == seen[4:0]);
endmodule

bind simd_imm_unit simd_imm_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_instr(in_instr), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_wr(out_wr), .out_rd(out_rd),
  .out_undef(out_undef), .out_unsup(out_unsup)
);

// File: tb/simd_imm_unit_test.sv
module simd_imm_unit_test;
  localparam int CW = 137;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_instr = '0;
  logic [127:0] in_old = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_result;
  logic         out_wr;
  logic [4:0]   out_rd;
  logic         out_undef;
  logic         out_unsup;

  int n_total = 0;
  int n_fail  = 0;

  simd_imm_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_old(in_old), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_wr(out_wr),
    .out_rd(out_rd), .out_undef(out_undef), .out_unsup(out_unsup)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] mk(input logic q, input logic opb,
                                     input logic [3:0] sel, input logic [7:0] imm,
                                     input logic [4:0] rd);
    return {1'b0, q, opb, 10'b0111100000, imm[7:5], sel, 2'b01, imm[4:0], rd};
  endfunction

  // {valid, wr, undef, unsup, rd, result}
  function automatic logic [CW-1:0] model(input logic [31:0] w, input logic [127:0] old);
    logic         hit;
    logic [3:0]   s;
    logic [7:0]   imm;
    logic [31:0]  lw;
    logic [15:0]  hw;
    logic [63:0]  pat;
    logic [127:0] full;
    logic [127:0] r;
    logic         und;
    hit = !w[31] && w[28:19] == 10'b0111100000 && !w[11] && w[10];
    s   = w[15:12];
    imm = {w[18:16], w[9:5]};
    if (!hit) return {1'b1, 3'b000, w[4:0], 128'd0};
    if (s[3:2] == 2'b11) begin
      und = (s == 4'hF) && w[29] && !w[30];
      return {1'b1, 1'b0, und, !und, w[4:0], 128'd0};
    end
    if (!s[3]) begin
      lw  = {24'd0, imm} << (8 * s[2:1]);
      pat = {lw, lw};
    end else begin
      hw  = {8'd0, imm} << (8 * s[1]);
      pat = {hw, hw, hw, hw};
    end
    full = {pat, pat};
    case ({s[0], w[29]})
      2'b00:   r = full;
      2'b01:   r = ~full;
      2'b10:   r = old | full;
      default: r = old & ~full;
    endcase
    if (!w[30]) r[127:64] = '0;
    return {1'b1, 3'b100, w[4:0], r};
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    if (!(!w[31] && w[28:19] == 10'b0111100000 && !w[11] && w[10])) return "R1";
    if (w[15:14] == 2'b11) return "R8";
    if (!w[30]) return "R6";
    if (w[15]) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] outs();
    return {out_valid, out_wr, out_undef, out_unsup, out_rd, out_result};
  endfunction

  task automatic send(input logic [31:0] w, input logic [127:0] old, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_instr = w; in_old = old; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, outs(), model(w, old));
  endtask

  initial begin
    #(20 * 200000);
    n_fail++; n_total++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    logic [127:0] ones;
    logic [31:0]  wa, wb;
    logic [CW-1:0] held;
    ones = '1;
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    check("R10", CW'({out_valid, in_ready}), CW'(2'b01));
    rst_n = 1'b1;

    // R2: field assembly and destination index
    send(mk(1, 0, 4'b0000, 8'hA5, 5'd17), '0, "R2");
    // R3: 32-bit lane shifts
    send(mk(1, 0, 4'b0110, 8'h81, 5'd3), '0, "R3");
    send(mk(1, 0, 4'b0011, 8'h3C, 5'd4), 128'h0123_4567_89AB_CDEF_0F0F_0F0F_F0F0_F0F0, "R3");
    // R4: 16-bit lane shifts
    send(mk(1, 0, 4'b1010, 8'hC3, 5'd5), '0, "R4");
    send(mk(1, 0, 4'b1001, 8'h11, 5'd6), 128'h8000_0000_0000_0000_0000_0000_0000_0001, "R4");
    // R5: inverted move and bit-clear
    send(mk(1, 1, 4'b0010, 8'hFF, 5'd7), '0, "R5");
    send(mk(1, 1, 4'b0101, 8'h5A, 5'd8), ones, "R5");
    send(mk(1, 1, 4'b1011, 8'hF0, 5'd9), ones, "R5");
    // R6: 64-bit operation clears upper half
    send(mk(0, 0, 4'b0001, 8'h77, 5'd10), ones, "R6");
    send(mk(0, 1, 4'b0000, 8'h00, 5'd11), '0, "R6");
    // R7 / R8: undefined and unsupported forms
    send(mk(0, 1, 4'hF, 8'h42, 5'd12), ones, "R7");
    send(mk(1, 1, 4'hF, 8'h42, 5'd13), ones, "R8");
    send(mk(1, 0, 4'b1100, 8'h42, 5'd14), ones, "R8");
    send(mk(0, 1, 4'b1110, 8'h42, 5'd15), ones, "R8");
    // R1: broken fixed fields
    send(mk(1, 0, 4'b0000, 8'hA5, 5'd1) & ~32'h0000_0400, ones, "R1");
    send(mk(1, 0, 4'b0000, 8'hA5, 5'd2) | 32'h8000_0000, ones, "R1");
    send(mk(1, 0, 4'b0000, 8'hA5, 5'd2) | 32'h0000_0800, ones, "R1");

    // R9: back-pressure
    wa = mk(1, 0, 4'b0100, 8'h99, 5'd20);
    wb = mk(1, 1, 4'b0001, 8'h66, 5'd21);
    @(negedge clk);
    in_valid = 1'b1; in_instr = wa; in_old = '0; out_ready = 1'b0;
    @(negedge clk);
    in_instr = wb; in_old = ones;
    check("R9", outs(), model(wa, '0));
    check("R9", CW'(in_ready), CW'(1'b0));
    held = outs();
    repeat (2) @(negedge clk);
    check("R9", outs(), held);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", outs(), model(wb, ones));
    @(negedge clk);
    check("R9", CW'({out_valid, in_ready}), CW'(2'b01));

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0]  r0, r1, w;
      logic [127:0] old;
      r0 = $urandom(); r1 = $urandom();
      old = {$urandom(), $urandom(), $urandom(), $urandom()};
      if (r1[2:0] == 3'd0) w = r0;
      else w = mk(r1[3], r1[4], r0[11:8], r0[7:0], r0[16:12]);
      send(w, old, tag_of(w));
    end

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule